// File: doc/BRIEF.md
# Sorted-Stream Run Colour Tagger

This block sits on a valid/ready stream of packets that an upstream stage has already sorted by destination. Packets bound for one destination row therefore arrive back to back, forming a run. The first packet of each run is the row leader. The block gives every packet a colour. Within a run, packets up to and including position `quota` count as black and the rest as white. `quota` is a programmable input, normally set to the grid size times the square root of the largest fan-in that any destination may see. Black packets take one routing order and white packets take the other, so the quota limits how much traffic any row carries in the black phase.

The block also flags the first packet of every run that shares one exact (row, column) destination. When combining mode is on, each later packet in such a run is marked as combined so that it can be dropped. Every surviving packet is then black, because after merging no destination receives more than one packet. A start-of-frame input, given with a packet, makes that packet open a fresh stream: the comparison history is discarded.

Each packet has one register stage between input and output. When the consumer holds back, the whole block stalls and the output stays frozen.

Top module: `run_colour_tagger`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An accepted packet has `out_row_lead` set when no packet has been accepted since reset, or when its row differs from the row of the previously accepted packet. Otherwise, and without start-of-frame, the flag is clear.
- R3: A packet accepted with `in_sof` set is a row leader even if its row equals the previous row. The following packets are compared against that packet.
- R4: With `combine_en` = 0, a packet at 1-based position p inside its row run has `out_black` = 1 if p <= `quota` and 0 otherwise. With `quota` = 0 every packet is white. `quota` is held constant within a run.
- R5: `out_dest_lead` is set when the packet is a row leader or when its column differs from the column of the previously accepted packet.
- R6: With `combine_en` = 1, a packet that is not a destination leader has `out_combined` = 1 and `out_black` = 0. A destination leader has `out_combined` = 0 and `out_black` = 1, whatever the value of `quota`.
- R7: With `combine_en` = 0, `out_combined` is always 0.
- R8: A packet accepted at a clock edge appears on the output after that same edge, with row, column and payload unchanged. Packets leave in the order they were accepted.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` = 1 and `out_ready` = 0, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input packet present |
| in_ready | output | 1 | Block can take a packet |
| in_sof | input | 1 | Packet opens a new sorted stream |
| in_row | input | ROW_W | Destination row |
| in_col | input | COL_W | Destination column |
| in_data | input | DATA_W | Payload |
| quota | input | QUOTA_W | Black packets allowed per row run |
| combine_en | input | 1 | Combining mode |
| out_valid | output | 1 | Output packet present |
| out_ready | input | 1 | Consumer takes the packet |
| out_row | output | ROW_W | Destination row |
| out_col | output | COL_W | Destination column |
| out_data | output | DATA_W | Payload |
| out_black | output | 1 | 1 = black, 0 = white |
| out_row_lead | output | 1 | First packet of a row run |
| out_dest_lead | output | 1 | First packet of an exact-destination run |
| out_combined | output | 1 | Duplicate to be merged (combining mode) |

## Verification
The leader decision and the backpressure stall can fall in the same cycle. The history must then stay put until the held packet is finally accepted. Otherwise a stalled leader would be compared against itself and lose its flag. The bench provokes this by driving a random `out_ready` while new runs and start-of-frame beats are arriving. Its queue-based model advances only on real handshakes and checks every field of the front packet on every clock, so repeated agreement across a stall also shows that the output held.

// File: rtl/rct_pkg.sv
package rct_pkg;
    typedef struct packed {
        logic black;
        logic row_lead;
        logic dest_lead;
        logic combined;
    } rct_tag_t;
endpackage

// File: rtl/rct_lead_detect.sv
module rct_lead_detect #(
    parameter int ROW_W = 4,
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             sof,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             row_lead,
    output logic             dest_lead
);
    typedef struct packed {
        logic             valid;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d    = hist_q;
        row_lead  = sof || !hist_q.valid || (row != hist_q.row);
        dest_lead = row_lead || (col != hist_q.col);
        if (adv) begin
            hist_d.valid = 1'b1;
            hist_d.row   = row;
            hist_d.col   = col;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/rct_run_count.sv
module rct_run_count #(
    parameter int QUOTA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               row_lead,
    input  logic [QUOTA_W-1:0] quota,
    output logic               black
);
    localparam int CNT_W = QUOTA_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] limit, pos_raw, pos;

    always_comb begin
        limit   = CNT_W'(quota) + CNT_W'(1);
        pos_raw = row_lead ? CNT_W'(1) : (cnt_q + CNT_W'(1));
        pos     = (pos_raw > limit) ? limit : pos_raw;
        black   = (pos <= CNT_W'(quota));
        cnt_d   = adv ? pos : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rct_out_reg.sv
module rct_out_reg
    import rct_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              drain,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] data_i,
    input  rct_tag_t          tag_i,
    output logic              valid_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [DATA_W-1:0] data_o,
    output rct_tag_t          tag_o
);
    typedef struct packed {
        logic              valid;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] data;
        rct_tag_t          tag;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (drain) slot_d.valid = 1'b0;
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.row   = row_i;
            slot_d.col   = col_i;
            slot_d.data  = data_i;
            slot_d.tag   = tag_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign valid_o = slot_q.valid;
    assign row_o   = slot_q.row;
    assign col_o   = slot_q.col;
    assign data_o  = slot_q.data;
    assign tag_o   = slot_q.tag;
endmodule

// File: rtl/run_colour_tagger.sv
module run_colour_tagger
    import rct_pkg::*;
#(
    parameter int ROW_W   = 4,
    parameter int COL_W   = 4,
    parameter int DATA_W  = 16,
    parameter int QUOTA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_sof,
    input  logic [ROW_W-1:0]   in_row,
    input  logic [COL_W-1:0]   in_col,
    input  logic [DATA_W-1:0]  in_data,
    input  logic [QUOTA_W-1:0] quota,
    input  logic               combine_en,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ROW_W-1:0]   out_row,
    output logic [COL_W-1:0]   out_col,
    output logic [DATA_W-1:0]  out_data,
    output logic               out_black,
    output logic               out_row_lead,
    output logic               out_dest_lead,
    output logic               out_combined
);
    logic     adv;
    logic     row_lead, dest_lead, quota_black;
    rct_tag_t tag_in, tag_out;

    assign in_ready = !out_valid || out_ready;
    assign adv      = in_valid && in_ready;

    rct_lead_detect #(.ROW_W(ROW_W), .COL_W(COL_W)) u_lead (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .sof       (in_sof),
        .row       (in_row),
        .col       (in_col),
        .row_lead  (row_lead),
        .dest_lead (dest_lead)
    );

    rct_run_count #(.QUOTA_W(QUOTA_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (adv),
        .row_lead (row_lead),
        .quota    (quota),
        .black    (quota_black)
    );

    always_comb begin
        tag_in.row_lead  = row_lead;
        tag_in.dest_lead = dest_lead;
        tag_in.combined  = combine_en && !dest_lead;
        tag_in.black     = combine_en ? dest_lead : quota_black;
    end

    rct_out_reg #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (adv),
        .drain   (out_ready),
        .row_i   (in_row),
        .col_i   (in_col),
        .data_i  (in_data),
        .tag_i   (tag_in),
        .valid_o (out_valid),
        .row_o   (out_row),
        .col_o   (out_col),
        .data_o  (out_data),
        .tag_o   (tag_out)
    );

    assign out_black     = tag_out.black;
    assign out_row_lead  = tag_out.row_lead;
    assign out_dest_lead = tag_out.dest_lead;
    assign out_combined  = tag_out.combined;
endmodule

// File: rtl/rct_checker.sv
module rct_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_black,
    input logic              out_row_lead,
    input logic              out_dest_lead,
    input logic              out_combined
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                      seen_q <= 1'b0;
        else if (out_valid && out_ready) seen_q <= 1'b1;
    end

    // R9
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_black)
            && $stable(out_row_lead) && $stable(out_dest_lead) && $stable(out_combined));

    // R9
    no_take_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R8
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    // R5
    lead_nesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_row_lead |-> out_dest_lead);

    // R6
    combined_white_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_combined |-> !out_black && !out_dest_lead);

    // R2
    first_is_leader_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !seen_q |-> out_row_lead);
endmodule

bind run_colour_tagger rct_checker #(.DATA_W(DATA_W)) i_rct_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .out_valid     (out_valid),
    .out_ready     (out_ready),
    .out_data      (out_data),
    .out_black     (out_black),
    .out_row_lead  (out_row_lead),
    .out_dest_lead (out_dest_lead),
    .out_combined  (out_combined)
);

// File: tb/test_run_colour_tagger.sv
module test_run_colour_tagger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, combine_en = 1'b0, out_ready = 1'b0;
    logic [3:0]  in_row = '0, in_col = '0;
    logic [15:0] in_data = '0;
    logic [7:0]  quota = '0;
    logic        in_ready, out_valid, out_black, out_row_lead, out_dest_lead, out_combined;
    logic [3:0]  out_row, out_col;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    run_colour_tagger i_run_colour_tagger (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
        .in_row(in_row), .in_col(in_col), .in_data(in_data), .quota(quota),
        .combine_en(combine_en), .out_valid(out_valid), .out_ready(out_ready),
        .out_row(out_row), .out_col(out_col), .out_data(out_data), .out_black(out_black),
        .out_row_lead(out_row_lead), .out_dest_lead(out_dest_lead), .out_combined(out_combined)
    );

    typedef struct {
        logic [3:0]  row, col;
        logic [15:0] data;
        bit          black, rl, dl, comb, forced, cmode;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0, checks = 0;
    bit   have_prev = 0;
    logic [3:0] prev_row, prev_col;
    int   pos = 0;
    logic [15:0] data_ctr = 16'h100;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic compare_front();
        exp_t e;
        if (exp_q.size() == 0) begin
            chk(0, "R8 unexpected output", 1, 0);
            return;
        end
        e = exp_q[0];
        chk(out_row == e.row && out_col == e.col, "R8 dest", {out_row, out_col}, {e.row, e.col});
        chk(out_data == e.data, "R8 data", out_data, e.data);
        chk(out_row_lead == e.rl, e.forced ? "R3 row_lead" : "R2 row_lead", out_row_lead, e.rl);
        chk(out_dest_lead == e.dl, "R5 dest_lead", out_dest_lead, e.dl);
        chk(out_black == e.black, e.cmode ? "R6 black" : "R4 black", out_black, e.black);
        chk(out_combined == e.comb, e.cmode ? "R6 combined" : "R7 combined", out_combined, e.comb);
    endtask

    task automatic model_push(input logic [3:0] r, input logic [3:0] c, input logic [15:0] d, input bit s);
        exp_t e;
        e.row = r; e.col = c; e.data = d; e.cmode = combine_en;
        e.forced = s || !have_prev;
        e.rl = s || !have_prev || (r != prev_row);
        e.dl = e.rl || (c != prev_col);
        if (e.rl) pos = 1; else pos++;
        if (combine_en) begin
            e.comb = !e.dl; e.black = e.dl;
        end else begin
            e.comb = 0; e.black = (pos <= int'(quota));
        end
        have_prev = 1; prev_row = r; prev_col = c;
        exp_q.push_back(e);
    endtask

    task automatic cyc(input bit iv, input logic [3:0] r, input logic [3:0] c, input bit s,
                       input bit ordy, output bit acc);
        in_valid = iv; in_row = r; in_col = c; in_data = data_ctr; in_sof = s; out_ready = ordy;
        #1;
        if (out_valid) compare_front();
        chk(in_ready == (!out_valid || out_ready), "R9 in_ready", in_ready, !out_valid || out_ready);
        if (out_valid && out_ready) void'(exp_q.pop_front());
        acc = iv && in_ready;
        if (acc) begin
            model_push(r, c, data_ctr, s);
            data_ctr++;
        end
        @(negedge clk);
    endtask

    task automatic send(input logic [3:0] r, input logic [3:0] c, input bit s, input int ready_pct);
        bit acc = 0;
        while (!acc) cyc(1, r, c, s, ($urandom_range(99) < ready_pct), acc);
    endtask

    task automatic drain();
        bit acc;
        for (int i = 0; i < 20 && (exp_q.size() != 0 || out_valid); i++) cyc(0, 0, 0, 0, 1, acc);
        chk(exp_q.size() == 0 && !out_valid, "R8 drained", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [3:0] r, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(in_ready == 1, "R1 in_ready", in_ready, 1);
        @(negedge clk);

        // R2 R4 R5: quota 2, row runs of 4, 2 and 1 packets
        quota = 8'd2; combine_en = 0;
        send(1, 0, 0, 100); send(1, 3, 0, 100); send(1, 3, 0, 100); send(1, 5, 0, 100);
        send(2, 0, 0, 100); send(2, 0, 0, 100); send(4, 7, 0, 100);
        drain();

        // R4 quota zero: all white
        quota = 8'd0;
        send(5, 1, 1, 100); send(5, 2, 0, 100); send(6, 2, 0, 100);
        drain();

        // R3 start-of-frame on a packet with the same row
        quota = 8'd1;
        send(6, 2, 0, 100); send(6, 2, 1, 100); send(6, 4, 0, 100);
        drain();

        // R6 combining mode with duplicates, quota ignored
        combine_en = 1; quota = 8'd0;
        send(0, 1, 1, 100); send(0, 1, 0, 100); send(0, 1, 0, 100); send(0, 2, 0, 100);
        send(3, 2, 0, 100); send(3, 2, 0, 100);
        drain();

        // R9 long stall while a new run begins
        combine_en = 0; quota = 8'd3;
        send(7, 0, 1, 100); send(7, 0, 0, 100);
        for (int i = 0; i < 6; i++) begin
            bit acc;
            cyc(1, 8, 1, 0, 0, acc);
        end
        send(8, 1, 0, 100); send(8, 1, 0, 30);
        drain();

        // random sorted frames, random backpressure and modes
        for (int f = 0; f < 60; f++) begin
            combine_en = ($urandom_range(3) == 0);
            quota = 8'($urandom_range(6));
            r = 4'($urandom_range(2)); c = 4'($urandom_range(3));
            for (int p = 0; p < 50; p++) begin
                send(r, c, (p == 0), 60);
                case ($urandom_range(3))
                    0: ;
                    1: if (c != 4'hF) c = c + 4'd1;
                    2: if (r != 4'hF) begin r = r + 4'd1; c = 4'($urandom_range(4)); end
                    default: if (c < 4'hD) c = c + 4'd2;
                endcase
            end
            drain();
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule